// File: doc/BRIEF.md
# Reconfigurable Crossbar Logic Sequencer

This block drives the control lines of a small crossbar of two-state switch cells and keeps a logical model of every cell, so that one array computes a chosen Boolean function of its operands. The array has two banks of input latch switches, two wired-AND columns and a single output switch. A switch is either closed or open. The result is not computed by a gate. It comes from a fixed series of phases. First every switch is opened. The operands are then latched into the input bank, copied into an AND column and captured onto the output switch. The column is opened again, and the output switch is read without being disturbed.

A client selects the function with a three-bit code, presents the operand bits and pulses `start`. The sequencer performs one phase per clock. It shows the current phase as a one-hot vector and places a drive code on each control line (float, positive, negative, ground or read level). After the read phase it raises `done` for one cycle, and `result` then holds the function value. Two things select the function. The first is the latch mode: an inverting latch closes a switch for a 0, and a non-inverting latch closes it for a 1. The second is the polarity of the capture. The two-input equivalence functions use both columns, one for each minterm, and merge them with a sequential OR on the output switch.

Top module: `xbar_gate_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `phase_oh`=0, `result`=0, every drive code is float (0), and all switches are open.
- R2: A `start` seen while idle with `func_sel` 0..5 makes `phase_oh` bit 0 go high in the next cycle. A `start` while busy, or with `func_sel` 6 or 7, is ignored. `busy` is high exactly while a phase is active.
- R3: The clear phase (bit 0) drives the positive code (1) on the input, column and output lines, and leaves every switch open.
- R4: The latch phase (bit 1) fills bank 0 inverting (switch closed when the bit is 0) for AND, NAND, XNOR and XOR, and non-inverting for NOR and OR. Bank 1 gets a non-inverting copy of bits 0 and 1 for XNOR and XOR and stays open otherwise. Lanes 2 and above stay open for XNOR and XOR.
- R5: Function codes 0 AND, 1 NAND, 2 NOR and 3 OR step one cycle each through phase bits 0, 1, 2, 3, 4, 8 (clear, latch, transfer-0, capture-0, open-0, read).
- R6: Function codes 4 XNOR and 5 XOR step through all nine phase bits 0..8 in order. Bits 5, 6 and 7 repeat the transfer, capture and open steps for column 1.
- R7: A capture closes the output switch when every switch in its column is open. For NAND and OR the capture is inverted: it closes the output when any switch in the column is closed.
- R8: The captures are ORed in sequence: once the output switch is closed, a later capture cannot open it.
- R9: `result` holds AND, NAND, NOR or OR of all operand bits, or XNOR or XOR of bits 0 and 1. XOR is the read-inverted XNOR.
- R10: The read phase (bit 8) drives the read code (4) on the output line and changes no switch. `done` pulses high for one cycle right after it, with `busy` low and `result` valid.
- R11: When `done` is high, every column switch is open.
- R12: Drive codes per phase: latch has input NEG (2); a transfer has input GND (3) and its column NEG; a capture has input and output NEG; an open step has its column POS; every idle line is float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| func_sel | input | 3 | Function code (0 AND, 1 NAND, 2 NOR, 3 OR, 4 XNOR, 5 XOR) |
| in_bits | input | NIN | Operand bits |
| busy | output | 1 | A phase is active |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 1 | Value read from the output switch |
| phase_oh | output | 9 | One-hot current phase |
| in_drv | output | 3 | Drive code on the input control line |
| col_drv | output | 2*3 | Drive codes of column 0 (low) and column 1 |
| out_drv | output | 3 | Drive code on the output control line |
| in_closed | output | 2*NIN | Input switch states, bank 0 low |
| col_closed | output | 2*NIN | Column switch states, column 0 low |
| out_closed | output | 1 | Output switch state |

## Verification
The bench runs every function over all operand patterns. For XNOR it targets the case where the first minterm closes the output and the second would open it: a design that overwrites the output instead of ORing into it would get XNOR of 1,1 wrong. It also holds `start` high with a different code through a whole sequence and issues the two unused codes. A design that restarted mid-sequence, or that accepted the spare codes, would show a wrong phase vector or a false `busy`. Each cycle it compares the switch states and drive codes against a behavioural model, so a destructive read or a column left closed after the open step is caught in the cycle it occurs.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int NPH  = 9;
    localparam int NCOL = 2;
    localparam int DW   = 3;

    typedef enum logic [3:0] {
        PH_CLEAR = 4'd0,
        PH_LATCH = 4'd1,
        PH_XFER0 = 4'd2,
        PH_CAP0  = 4'd3,
        PH_OPEN0 = 4'd4,
        PH_XFER1 = 4'd5,
        PH_CAP1  = 4'd6,
        PH_OPEN1 = 4'd7,
        PH_READ  = 4'd8,
        PH_IDLE  = 4'd15
    } phase_e;

    localparam logic [DW-1:0] DRV_FLOAT = 3'd0;
    localparam logic [DW-1:0] DRV_POS   = 3'd1;
    localparam logic [DW-1:0] DRV_NEG   = 3'd2;
    localparam logic [DW-1:0] DRV_GND   = 3'd3;
    localparam logic [DW-1:0] DRV_READ  = 3'd4;

    localparam logic [2:0] FN_AND  = 3'd0;
    localparam logic [2:0] FN_NAND = 3'd1;
    localparam logic [2:0] FN_NOR  = 3'd2;
    localparam logic [2:0] FN_OR   = 3'd3;
    localparam logic [2:0] FN_XNOR = 3'd4;
    localparam logic [2:0] FN_XOR  = 3'd5;

    typedef struct packed {
        logic grp0_inv;  // bank 0 latches inverted
        logic cap_inv;   // capture closes on a blocked path
        logic two_min;   // two-minterm sequence
        logic rd_inv;    // result inverted at read
    } op_cfg_t;

    function automatic logic fn_valid(input logic [2:0] f);
        return f <= FN_XOR;
    endfunction

    function automatic op_cfg_t cfg_of(input logic [2:0] f);
        op_cfg_t c;
        c.grp0_inv = (f == FN_AND) || (f == FN_NAND) || (f == FN_XNOR) || (f == FN_XOR);
        c.cap_inv  = (f == FN_NAND) || (f == FN_OR);
        c.two_min  = (f == FN_XNOR) || (f == FN_XOR);
        c.rd_inv   = (f == FN_XOR);
        return c;
    endfunction

endpackage

// File: rtl/xbar_phase_ctrl.sv
module xbar_phase_ctrl
    import xbar_pkg::*;
#(
    parameter int NIN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     func_sel,
    input  logic [NIN-1:0] in_bits,
    output phase_e         phase,
    output op_cfg_t        cfg,
    output logic [NIN-1:0] op_bits,
    output logic           busy,
    output logic           done
);

    typedef struct packed {
        phase_e         phase;
        op_cfg_t        cfg;
        logic [NIN-1:0] bits;
        logic           done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start && fn_valid(func_sel)) begin
                    st_d.phase = PH_CLEAR;
                    st_d.cfg   = cfg_of(func_sel);
                    st_d.bits  = in_bits;
                end
            end
            PH_CLEAR: st_d.phase = PH_LATCH;
            PH_LATCH: st_d.phase = PH_XFER0;
            PH_XFER0: st_d.phase = PH_CAP0;
            PH_CAP0:  st_d.phase = PH_OPEN0;
            PH_OPEN0: st_d.phase = st_q.cfg.two_min ? PH_XFER1 : PH_READ;
            PH_XFER1: st_d.phase = PH_CAP1;
            PH_CAP1:  st_d.phase = PH_OPEN1;
            PH_OPEN1: st_d.phase = PH_READ;
            PH_READ: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cfg   <= '0;
            st_q.bits  <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign cfg     = st_q.cfg;
    assign op_bits = st_q.bits;
    assign busy    = (st_q.phase != PH_IDLE);
    assign done    = st_q.done;

endmodule

// File: rtl/xbar_drive_map.sv
module xbar_drive_map
    import xbar_pkg::*;
(
    input  phase_e              phase,
    output logic [DW-1:0]       in_drv,
    output logic [NCOL*DW-1:0]  col_drv,
    output logic [DW-1:0]       out_drv
);

    always_comb begin
        unique case (phase)
            PH_CLEAR:         in_drv = DRV_POS;
            PH_LATCH:         in_drv = DRV_NEG;
            PH_XFER0, PH_XFER1: in_drv = DRV_GND;
            PH_CAP0, PH_CAP1: in_drv = DRV_NEG;
            default:          in_drv = DRV_FLOAT;
        endcase
    end

    always_comb begin
        unique case (phase)
            PH_CLEAR:         out_drv = DRV_POS;
            PH_CAP0, PH_CAP1: out_drv = DRV_NEG;
            PH_READ:          out_drv = DRV_READ;
            default:          out_drv = DRV_FLOAT;
        endcase
    end

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        localparam phase_e XF = (k == 0) ? PH_XFER0 : PH_XFER1;
        localparam phase_e OP = (k == 0) ? PH_OPEN0 : PH_OPEN1;
        always_comb begin
            if (phase == PH_CLEAR || phase == OP)
                col_drv[k*DW +: DW] = DRV_POS;
            else if (phase == XF)
                col_drv[k*DW +: DW] = DRV_NEG;
            else
                col_drv[k*DW +: DW] = DRV_FLOAT;
        end
    end

endmodule

// File: rtl/xbar_cell_model.sv
module xbar_cell_model
    import xbar_pkg::*;
#(
    parameter int NIN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase,
    input  op_cfg_t             cfg,
    input  logic [NIN-1:0]      op_bits,
    output logic [NCOL*NIN-1:0] in_closed,
    output logic [NCOL*NIN-1:0] col_closed,
    output logic                out_closed,
    output logic                result
);

    typedef struct packed {
        logic [NCOL*NIN-1:0] in_sw;
        logic [NCOL*NIN-1:0] col_sw;
        logic                out_sw;
        logic                res;
    } cell_t;

    cell_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        unique case (phase)
            PH_CLEAR: begin
                cs_d.in_sw  = '0;
                cs_d.col_sw = '0;
                cs_d.out_sw = 1'b0;
            end
            PH_LATCH: begin
                for (int i = 0; i < NIN; i++) begin
                    cs_d.in_sw[i] = (!cfg.two_min || i < 2) &&
                                    (cfg.grp0_inv ? !op_bits[i] : op_bits[i]);
                    cs_d.in_sw[NIN+i] = (i < 2) && cfg.two_min && op_bits[i];
                end
            end
            PH_XFER0: cs_d.col_sw[0 +: NIN]   = cs_q.in_sw[0 +: NIN];
            PH_XFER1: cs_d.col_sw[NIN +: NIN] = cs_q.in_sw[NIN +: NIN];
            PH_CAP0:  cs_d.out_sw = cs_q.out_sw |
                                    ((~|cs_q.col_sw[0 +: NIN]) ^ cfg.cap_inv);
            PH_CAP1:  cs_d.out_sw = cs_q.out_sw |
                                    ((~|cs_q.col_sw[NIN +: NIN]) ^ cfg.cap_inv);
            PH_OPEN0: cs_d.col_sw[0 +: NIN]   = '0;
            PH_OPEN1: cs_d.col_sw[NIN +: NIN] = '0;
            PH_READ:  cs_d.res = cs_q.out_sw ^ cfg.rd_inv;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign in_closed  = cs_q.in_sw;
    assign col_closed = cs_q.col_sw;
    assign out_closed = cs_q.out_sw;
    assign result     = cs_q.res;

endmodule

// File: rtl/xbar_gate_seq.sv
module xbar_gate_seq
    import xbar_pkg::*;
#(
    parameter int NIN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          func_sel,
    input  logic [NIN-1:0]      in_bits,
    output logic                busy,
    output logic                done,
    output logic                result,
    output logic [NPH-1:0]      phase_oh,
    output logic [DW-1:0]       in_drv,
    output logic [NCOL*DW-1:0]  col_drv,
    output logic [DW-1:0]       out_drv,
    output logic [NCOL*NIN-1:0] in_closed,
    output logic [NCOL*NIN-1:0] col_closed,
    output logic                out_closed
);

    phase_e         phase;
    op_cfg_t        cfg;
    logic [NIN-1:0] op_bits;

    xbar_phase_ctrl #(.NIN(NIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel),
        .in_bits(in_bits), .phase(phase), .cfg(cfg), .op_bits(op_bits),
        .busy(busy), .done(done)
    );

    xbar_drive_map u_drv (
        .phase(phase), .in_drv(in_drv), .col_drv(col_drv), .out_drv(out_drv)
    );

    xbar_cell_model #(.NIN(NIN)) u_cells (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cfg(cfg), .op_bits(op_bits),
        .in_closed(in_closed), .col_closed(col_closed),
        .out_closed(out_closed), .result(result)
    );

    for (genvar k = 0; k < NPH; k++) begin : g_oh
        assign phase_oh[k] = (phase == phase_e'(k));
    end

endmodule

// File: rtl/xbar_gate_seq_chk.sv
module xbar_gate_seq_chk
    import xbar_pkg::*;
#(
    parameter int NIN = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [2:0]          func_sel,
    input logic                busy,
    input logic                done,
    input logic [NPH-1:0]      phase_oh,
    input logic [DW-1:0]       in_drv,
    input logic [DW-1:0]       out_drv,
    input logic [NCOL*NIN-1:0] in_closed,
    input logic [NCOL*NIN-1:0] col_closed,
    input logic                out_closed
);

    assert_phase_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_oh));

    assert_busy_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (phase_oh != '0));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && func_sel <= 3'd5) |=> phase_oh[0]);

    assert_clear_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |=> (in_closed == '0 && col_closed == '0 && !out_closed));

    assert_clear_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |-> (in_drv == DRV_POS && out_drv == DRV_POS));

    assert_latch_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[1] |=> phase_oh[2]);

    assert_seq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[6] && out_closed) |=> out_closed);

    assert_read_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[8] |=> ($stable(in_closed) && $stable(col_closed) && $stable(out_closed)));

    assert_read_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[8] |-> (out_drv == DRV_READ && in_drv == DRV_FLOAT));

    assert_done_cols_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (col_closed == '0 && !busy));

endmodule

bind xbar_gate_seq xbar_gate_seq_chk #(.NIN(NIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel),
    .busy(busy), .done(done), .phase_oh(phase_oh), .in_drv(in_drv),
    .out_drv(out_drv), .in_closed(in_closed), .col_closed(col_closed),
    .out_closed(out_closed)
);

// File: tb/test_xbar_gate_seq.sv
module test_xbar_gate_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NIN  = 3;
    localparam int NCOL = 2;
    localparam int NPH  = 9;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [2:0]          func_sel = 3'd0;
    logic [NIN-1:0]      in_bits = '0;
    logic                busy, done, result, out_closed;
    logic [NPH-1:0]      phase_oh;
    logic [2:0]          in_drv, out_drv;
    logic [NCOL*3-1:0]   col_drv;
    logic [NCOL*NIN-1:0] in_closed, col_closed;

    xbar_gate_seq #(.NIN(NIN)) i_xbar_gate_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel),
        .in_bits(in_bits), .busy(busy), .done(done), .result(result),
        .phase_oh(phase_oh), .in_drv(in_drv), .col_drv(col_drv),
        .out_drv(out_drv), .in_closed(in_closed), .col_closed(col_closed),
        .out_closed(out_closed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural reference state
    int cur = -1;
    int phq[$];
    logic [NCOL*NIN-1:0] m_in = '0, m_col = '0;
    logic m_out = 0, m_res = 0, m_done = 0;
    logic [2:0] m_f = 0;
    logic [NIN-1:0] m_b = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_in_drv(input int p);
        case (p)
            0: return 3'd1;
            1: return 3'd2;
            2, 5: return 3'd3;
            3, 6: return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] exp_out_drv(input int p);
        case (p)
            0: return 3'd1;
            3, 6: return 3'd2;
            8: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] exp_col_drv(input int p, input int k);
        if (p == 0 || p == 4 + 3*k) return 3'd1;
        if (p == 2 + 3*k) return 3'd2;
        return 3'd0;
    endfunction

    task automatic apply_phase(input int p);
        bit inv0, capinv, two, open_path;
        inv0   = (m_f == 0 || m_f == 1 || m_f == 4 || m_f == 5);
        capinv = (m_f == 1 || m_f == 3);
        two    = (m_f >= 4);
        case (p)
            0: begin m_in = '0; m_col = '0; m_out = 0; end
            1: for (int i = 0; i < NIN; i++) begin
                   m_in[i]     = (!two || i < 2) ? (inv0 ? !m_b[i] : m_b[i]) : 1'b0;
                   m_in[NIN+i] = (two && i < 2) ? m_b[i] : 1'b0;
               end
            2: for (int i = 0; i < NIN; i++) m_col[i] = m_in[i];
            5: for (int i = 0; i < NIN; i++) m_col[NIN+i] = m_in[NIN+i];
            3, 6: begin
                open_path = 1;
                for (int i = 0; i < NIN; i++)
                    if (m_col[(p == 3 ? 0 : NIN) + i]) open_path = 0;
                if (capinv ? !open_path : open_path) m_out = 1;
            end
            4: for (int i = 0; i < NIN; i++) m_col[i] = 0;
            7: for (int i = 0; i < NIN; i++) m_col[NIN+i] = 0;
            8: m_res = m_out ^ (m_f == 5);
            default: ;
        endcase
    endtask

    task automatic model_step(input logic s, input logic [2:0] f, input logic [NIN-1:0] b);
        int old;
        old = cur;
        if (old >= 0) apply_phase(old);
        m_done = (old == 8);
        if (old < 0) begin
            if (s && f <= 5) begin
                m_f = f; m_b = b;
                phq = {0, 1, 2, 3, 4};
                if (f >= 4) begin phq.push_back(5); phq.push_back(6); phq.push_back(7); end
                phq.push_back(8);
                cur = phq.pop_front();
            end
        end else begin
            cur = (phq.size() > 0) ? phq.pop_front() : -1;
        end
    endtask

    task automatic compare_all();
        logic [NPH-1:0] eoh;
        eoh = (cur >= 0) ? (NPH'(1) << cur) : '0;
        check("R2", "busy", 32'(busy), 32'(cur >= 0));
        check("R5/R6", "phase_oh", 32'(phase_oh), 32'(eoh));
        check("R12", "in_drv", 32'(in_drv), 32'(exp_in_drv(cur)));
        check("R12", "out_drv", 32'(out_drv), 32'(exp_out_drv(cur)));
        for (int k = 0; k < NCOL; k++)
            check("R12", "col_drv", 32'(col_drv[k*3 +: 3]), 32'(exp_col_drv(cur, k)));
        check("R4", "in_closed", 32'(in_closed), 32'(m_in));
        check("R3", "col_closed", 32'(col_closed), 32'(m_col));
        check("R7", "out_closed", 32'(out_closed), 32'(m_out));
        check("R9", "result", 32'(result), 32'(m_res));
        check("R10", "done", 32'(done), 32'(m_done));
    endtask

    task automatic cycle(input logic s, input logic [2:0] f, input logic [NIN-1:0] b);
        start = s; func_sel = f; in_bits = b;
        @(posedge clk);
        model_step(s, f, b);
        #1;
        compare_all();
    endtask

    function automatic logic golden(input logic [2:0] f, input logic [NIN-1:0] b);
        case (f)
            3'd0: return &b;
            3'd1: return ~&b;
            3'd2: return ~|b;
            3'd3: return |b;
            3'd4: return ~(b[0] ^ b[1]);
            default: return b[0] ^ b[1];
        endcase
    endfunction

    task automatic run_op(input logic [2:0] f, input logic [NIN-1:0] b,
                          input logic hold_start, input logic [2:0] f_noise);
        cycle(1'b1, f, b);
        for (int n = 0; n < 12; n++) begin
            cycle(hold_start, hold_start ? f_noise : f, ~b);
            if (m_done) break;
        end
        check("R10", "done pulse seen", 32'(done), 32'd1);
        // R8: XNOR of 1,1 closes on minterm 0; minterm 1 must not reopen it
        check("R9", "function value", 32'(result), 32'(golden(f, b)));
        check("R11", "columns open at done", 32'(col_closed), 32'd0);
        check("R10", "busy low at done", 32'(busy), 32'd0);
        start = 1'b0;
        cycle(1'b0, f, b);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "phase_oh", 32'(phase_oh), 32'd0);
        check("R1", "result", 32'(result), 32'd0);
        check("R1", "drives", 32'({in_drv, col_drv, out_drv}), 32'd0);
        check("R1", "switches", 32'({in_closed, col_closed, out_closed}), 32'd0);
        cycle(1'b0, 3'd0, '0);

        for (int f = 0; f < 6; f++)
            for (int b = 0; b < (1 << NIN); b++)
                run_op(3'(f), NIN'(b), 1'b0, 3'd0);

        // R2: start held with another code during a sequence is ignored
        run_op(3'd0, 3'b111, 1'b1, 3'd2);
        run_op(3'd4, 3'b011, 1'b1, 3'd1);

        // R2: spare codes 6 and 7 are ignored
        cycle(1'b1, 3'd6, 3'b101);
        check("R2", "code 6 ignored", 32'(busy), 32'd0);
        cycle(1'b1, 3'd7, 3'b101);
        check("R2", "code 7 ignored", 32'(busy), 32'd0);
        cycle(1'b0, 3'd0, '0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule